// File: doc/BRIEF.md
# Transmit Buffer State Tracker

This block tracks the life cycle of a single transmit frame buffer inside a CAN-style controller. Software sends three single-cycle command pulses: make the buffer empty, mark it ready to send, and abort it. The protocol engine sends event pulses: the buffer was picked for sending, the frame went out cleanly, an error frame occurred, or arbitration was lost. A level qualifier from the engine reports that the retransmit limit has been reached.

The block holds one of seven states. It presents that state as a 3-bit code, and a ready flag that the transmit scheduler uses to find candidate buffers. An abort that arrives while a frame is on the bus does not stop the frame at once. The buffer waits in an abort-pending state until the next error frame or lost arbitration. If the frame completes cleanly first, the abort is dropped. A command that does not apply to the current state is ignored with no effect.

Top module: `txb_state_top`

## Requirements
- R1: After reset the state code is Empty (0) and the ready flag is low.
- R2: State codes are Empty=0, Ready=1, Sending=2, Abort pending=3, Sent OK=4, Send failed=5, Aborted=6. The ready flag is high exactly when the code is 1.
- R3: Command bit 0 is make-empty, bit 1 is make-ready and bit 2 is abort. When several bits are high in one cycle, only one command is taken, by the priority abort > make-ready > make-empty. This holds even if the chosen command has no effect in the current state.
- R4: Make-empty moves Sent OK, Send failed or Aborted to Empty. In every other state it has no effect.
- R5: Make-ready moves Sent OK, Send failed, Aborted or Empty to Ready. In every other state it has no effect.
- R6: Abort moves Ready directly to Aborted.
- R7: Abort moves Sending to Abort pending. In every state other than Ready and Sending it has no effect.
- R8: A select event moves Ready to Sending. In every other state it is ignored.
- R9: In Sending, success goes to Sent OK. An error frame or lost arbitration goes back to Ready, or goes to Send failed when the limit qualifier is high. Success wins over a simultaneous error or arbitration loss.
- R10: In Abort pending, an error frame or lost arbitration goes to Aborted whatever the limit qualifier says. Success goes to Sent OK.
- R11: When an engine event and a command fall in the same cycle, the event is applied first. The command is then judged against the state the event produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | CMD_W (3) | Command pulses: bit0 make-empty, bit1 make-ready, bit2 abort |
| tx_select_i | input | 1 | Engine picked this buffer for sending |
| tx_ok_i | input | 1 | Frame sent successfully |
| tx_err_i | input | 1 | Error frame seen |
| tx_arb_lost_i | input | 1 | Arbitration lost |
| tx_limit_i | input | 1 | Retransmit limit reached (qualifies error or arbitration loss) |
| state_o | output | 3 | Encoded buffer state |
| ready_o | output | 1 | Buffer is Ready |

## Verification
The engine path and the software command path can both act on the buffer in the same clock cycle. The bench drives an event and a command together on the same edge from states where the order matters. Examples are a select with an abort from Ready, a failure with make-ready, and an arbitration loss with make-ready while the abort is pending. The result must match the state reached by applying the event first and then the command. A second set of cycles raises several command bits together and checks that only the highest-priority one is taken, including the case where that command has no effect.

// File: rtl/txb_pkg.sv
package txb_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    S_EMPTY    = 3'd0,
    S_READY    = 3'd1,
    S_SENDING  = 3'd2,
    S_ABORTING = 3'd3,
    S_SENT_OK  = 3'd4,
    S_FAILED   = 3'd5,
    S_ABORTED  = 3'd6
  } buf_state_e;

  typedef enum logic [1:0] {
    C_NONE,
    C_EMPTY,
    C_READY,
    C_ABORT
  } buf_cmd_e;

  localparam int CMD_BIT_EMPTY = 0;
  localparam int CMD_BIT_READY = 1;
  localparam int CMD_BIT_ABORT = 2;

  typedef struct packed {
    logic sel;
    logic ok;
    logic err;
    logic arb;
    logic lim;
  } eng_evt_t;
endpackage

// File: rtl/txb_cmd_dec.sv
module txb_cmd_dec
  import txb_pkg::*;
#(
  parameter int CMD_W = 3
) (
  input  logic [CMD_W-1:0] cmd_i,
  output buf_cmd_e         cmd_o
);
  // fixed priority: abort > ready > empty
  always_comb begin
    if (cmd_i[CMD_BIT_ABORT])      cmd_o = C_ABORT;
    else if (cmd_i[CMD_BIT_READY]) cmd_o = C_READY;
    else if (cmd_i[CMD_BIT_EMPTY]) cmd_o = C_EMPTY;
    else                           cmd_o = C_NONE;
  end
endmodule

// File: rtl/txb_evt_step.sv
module txb_evt_step
  import txb_pkg::*;
(
  input  buf_state_e state_i,
  input  eng_evt_t   evt_i,
  output buf_state_e state_o
);
  logic fault;
  assign fault = evt_i.err | evt_i.arb;

  always_comb begin
    state_o = state_i;
    unique case (state_i)
      S_READY:    if (evt_i.sel) state_o = S_SENDING;
      S_SENDING: begin
        if (evt_i.ok)   state_o = S_SENT_OK;
        else if (fault) state_o = evt_i.lim ? S_FAILED : S_READY;
      end
      S_ABORTING: begin
        if (evt_i.ok)   state_o = S_SENT_OK;
        else if (fault) state_o = S_ABORTED;
      end
      default: state_o = state_i;
    endcase
  end
endmodule

// File: rtl/txb_cmd_step.sv
module txb_cmd_step
  import txb_pkg::*;
(
  input  buf_state_e state_i,
  input  buf_cmd_e   cmd_i,
  output buf_state_e state_o
);
  logic done_st;
  assign done_st = (state_i == S_SENT_OK) || (state_i == S_FAILED) || (state_i == S_ABORTED);

  always_comb begin
    state_o = state_i;
    unique case (cmd_i)
      C_EMPTY: if (done_st) state_o = S_EMPTY;
      C_READY: if (done_st || state_i == S_EMPTY) state_o = S_READY;
      C_ABORT: begin
        if (state_i == S_READY)        state_o = S_ABORTED;
        else if (state_i == S_SENDING) state_o = S_ABORTING;
      end
      default: state_o = state_i;
    endcase
  end
endmodule

// File: rtl/txb_state_top.sv
module txb_state_top
  import txb_pkg::*;
#(
  parameter int CMD_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             tx_select_i,
  input  logic             tx_ok_i,
  input  logic             tx_err_i,
  input  logic             tx_arb_lost_i,
  input  logic             tx_limit_i,
  output logic [2:0]       state_o,
  output logic             ready_o
);
  buf_state_e state_q, after_evt, after_cmd;
  buf_cmd_e   cmd_sel;
  eng_evt_t   evt;

  assign evt = '{sel: tx_select_i, ok: tx_ok_i, err: tx_err_i, arb: tx_arb_lost_i, lim: tx_limit_i};

  txb_cmd_dec #(.CMD_W(CMD_W)) u_dec (.cmd_i(cmd_i), .cmd_o(cmd_sel));

  // event stage first, command stage sees its result
  txb_evt_step u_evt (.state_i(state_q), .evt_i(evt), .state_o(after_evt));
  txb_cmd_step u_cmd (.state_i(after_evt), .cmd_i(cmd_sel), .state_o(after_cmd));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_EMPTY;
    else         state_q <= after_cmd;
  end

  assign state_o = state_q;
  assign ready_o = (state_q == S_READY);

  logic quiet_evt;
  assign quiet_evt = !tx_select_i && !tx_ok_i && !tx_err_i && !tx_arb_lost_i;

  a_r2_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 3'd7);

  a_r4_empty_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o inside {3'd4, 3'd5, 3'd6}) && cmd_i == 3'b001 |=> state_o == 3'd0);

  a_r6_abort_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd1 && !tx_select_i && cmd_i[2] |=> state_o == 3'd6);

  a_r7_abort_sending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd2 && quiet_evt && cmd_i[2] |=> state_o == 3'd3);

  a_r8_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd1 && tx_select_i && cmd_i == '0 |=> state_o == 3'd2);

  a_r10_abort_settle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd3 && !tx_ok_i && (tx_err_i || tx_arb_lost_i) && cmd_i == '0
      |=> state_o == 3'd6);

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet_evt && cmd_i == '0 |=> $stable(state_o));
endmodule

// File: tb/sim_txb_state_top.sv
module sim_txb_state_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd = '0;
  logic       sel = 0, ok = 0, err = 0, arb = 0, lim = 0;
  logic [2:0] st;
  logic       rdy;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  txb_state_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd),
    .tx_select_i(sel), .tx_ok_i(ok), .tx_err_i(err),
    .tx_arb_lost_i(arb), .tx_limit_i(lim),
    .state_o(st), .ready_o(rdy)
  );

  task automatic chk(string req, logic [2:0] exp);
    checks++;
    if (st !== exp || rdy !== (exp == 3'd1)) begin
      fails++;
      $display("FAIL %s: state=%0d ready=%0b expected state=%0d ready=%0b",
               req, st, rdy, exp, exp == 3'd1);
    end
  endtask

  // one cycle of stimulus; inputs change on negedge, result read on next negedge
  task automatic step(logic [2:0] c, logic s = 0, logic o = 0, logic e = 0,
                      logic a = 0, logic l = 0);
    @(negedge clk);
    cmd = c; sel = s; ok = o; err = e; arb = a; lim = l;
    @(negedge clk);
    cmd = '0; sel = 0; ok = 0; err = 0; arb = 0; lim = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic reach(int target);
    do_reset();
    case (target)
      1: step(3'b010);
      2: begin step(3'b010); step(3'b000, 1); end
      3: begin step(3'b010); step(3'b000, 1); step(3'b100); end
      4: begin step(3'b010); step(3'b000, 1); step(3'b000, 0, 1); end
      5: begin step(3'b010); step(3'b000, 1); step(3'b000, 0, 0, 1, 0, 1); end
      6: begin step(3'b010); step(3'b100); end
      default: ;
    endcase
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset", 3'd0);
    step(3'b000);
    chk("R1 idle after reset", 3'd0);
  endtask

  task automatic t_empty_cmd();
    for (int s = 0; s < 7; s++) begin
      logic [2:0] exp;
      reach(s);
      exp = (s >= 4) ? 3'd0 : 3'(s);
      step(3'b001);
      chk($sformatf("R4 make-empty from %0d", s), exp);
    end
  endtask

  task automatic t_ready_cmd();
    for (int s = 0; s < 7; s++) begin
      logic [2:0] exp;
      reach(s);
      exp = (s >= 4 || s == 0) ? 3'd1 : 3'(s);
      step(3'b010);
      chk($sformatf("R5 make-ready from %0d", s), exp);
    end
  endtask

  task automatic t_abort_cmd();
    for (int s = 0; s < 7; s++) begin
      logic [2:0] exp;
      reach(s);
      exp = (s == 1) ? 3'd6 : (s == 2) ? 3'd3 : 3'(s);
      step(3'b100);
      chk($sformatf("R6 R7 abort from %0d", s), exp);
    end
  endtask

  task automatic t_send_flow();
    reach(1); step(3'b000, 1); chk("R8 select from Ready", 3'd2);
    reach(0); step(3'b000, 1); chk("R8 select ignored in Empty", 3'd0);
    reach(4); step(3'b000, 1); chk("R8 select ignored in Sent OK", 3'd4);
    reach(2); step(3'b000, 0, 1); chk("R9 success", 3'd4);
    reach(2); step(3'b000, 0, 0, 1); chk("R9 error retry", 3'd1);
    reach(2); step(3'b000, 0, 0, 0, 1); chk("R9 arb lost retry", 3'd1);
    reach(2); step(3'b000, 0, 0, 0, 1, 1); chk("R9 limit to failed", 3'd5);
    reach(2); step(3'b000, 0, 1, 1); chk("R9 success wins over error", 3'd4);
    reach(1); step(3'b000, 0, 1, 1); chk("R9 ok/err ignored in Ready", 3'd1);
  endtask

  task automatic t_abort_flow();
    reach(3); step(3'b000, 0, 0, 1); chk("R10 error settles abort", 3'd6);
    reach(3); step(3'b000, 0, 0, 0, 1, 1); chk("R10 arb lost with limit", 3'd6);
    reach(3); step(3'b000, 0, 1); chk("R10 success drops abort", 3'd4);
    reach(3); step(3'b000, 1); chk("R10 select ignored pending", 3'd3);
  endtask

  task automatic t_same_cycle();
    reach(1); step(3'b100, 1); chk("R11 select+abort", 3'd3);
    reach(2); step(3'b001, 0, 1); chk("R11 success+empty", 3'd0);
    reach(2); step(3'b100, 0, 0, 1); chk("R11 error+abort", 3'd6);
    reach(2); step(3'b010, 0, 0, 1, 0, 1); chk("R11 fail+ready", 3'd1);
    reach(3); step(3'b010, 0, 0, 0, 1); chk("R11 pending arb+ready", 3'd1);
  endtask

  task automatic t_multi_cmd();
    reach(4); step(3'b011); chk("R3 ready over empty", 3'd1);
    reach(1); step(3'b111); chk("R3 abort over all", 3'd6);
    reach(4); step(3'b101); chk("R3 abort wins and is void", 3'd4);
    reach(2); step(3'b110); chk("R3 abort over ready in Sending", 3'd3);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_empty_cmd();
    t_ready_cmd();
    t_abort_cmd();
    t_send_flow();
    t_abort_flow();
    t_same_cycle();
    t_multi_cmd();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule